// File: doc/BRIEF.md
# Double-Buffered DAC Code Register

This block is the digital front end of a voltage-output digital-to-analog converter. A parallel data bus is captured into a first storage stage, the staging register, and from there it is passed into a second stage, the output register. Only the output register drives the converter code. Three active-low controls govern the transfers: a select line, a shared write strobe, and a transfer line. The select line and the write strobe open the staging register. The transfer line and the write strobe open the output register.

Both stages act as level-sensitive latches. While a stage is open it is transparent within the same cycle. When it closes, it keeps the value it held at the last clock edge while it was open. Either stage can be held open, and so can both at once. With both open, the bus flows straight through to the code. The block also reports the ideal output magnitude in millivolts for a given reference, using code/2^W of full scale. This output is intended for checking.

Top module: `dbuf_dac`

## Requirements
- R1: While `rst_n` is low, `dac_code` reads 0. At the first clock edge with `rst_n` low, both registers are cleared to 0.
- R2: While `sel_n` and `wstrobe_n` are both low, the staging register follows `data_in`.
- R3: While `xfer_n` and `wstrobe_n` are both low, the output register, and therefore `dac_code`, follows the staging register's current value.
- R4: While `wstrobe_n` is high, neither register changes, whatever the levels of `sel_n` and `xfer_n` and whatever is on the bus.
- R5: With `sel_n`, `xfer_n` and `wstrobe_n` all low, `dac_code` equals `data_in` in the same cycle.
- R6: A stage closes when any of its two controls goes high. It then keeps the value it had at the last clock edge while it was open.
- R7: `out_mv` equals floor(`dac_code` × `VREF_MV` / 2^`DATA_W`). With the default values, code 255 gives 9960 and code 128 gives 5000.
- R8: While `xfer_n` is high, changes to the staging register do not reach `dac_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for both stages |
| rst_n | input | 1 | Active-low synchronous clear |
| sel_n | input | 1 | Active-low select for the staging register |
| wstrobe_n | input | 1 | Active-low write strobe shared by both stages |
| xfer_n | input | 1 | Active-low transfer into the output register |
| data_in | input | DATA_W | Parallel data bus |
| dac_code | output | DATA_W | Converter code taken from the output register |
| out_mv | output | MV_W | Ideal output magnitude in millivolts |

## Verification
The bench builds the block with its defaults: an 8-bit path and a 10000 mV reference. These values reach both ends of the transfer function, where code 255 lands one LSB below the reference at 9960 mV. The bench directs a two-step load, a simultaneous flow-through, and a hold with a busy bus. It then adds random mixes of the three control levels. Together these cover every combination of open and closed stages, and they also cover closing by each of the three controls.

// File: rtl/dbuf_dac_pkg.sv
package dbuf_dac_pkg;
  typedef enum logic [1:0] {
    ST_CLOSED = 2'b00,
    ST_OPEN   = 2'b01
  } stage_mode_e;

  function automatic int unsigned ideal_mv(input int unsigned code,
                                           input int unsigned vref_mv,
                                           input int unsigned bits);
    int unsigned prod;
    prod = code * vref_mv;
    return prod >> bits;
  endfunction
endpackage

// File: rtl/dbuf_stage.sv
module dbuf_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  import dbuf_dac_pkg::*;

  stage_mode_e mode;
  logic [W-1:0] held_q;

  assign mode = open_i ? ST_OPEN : ST_CLOSED;

  always_comb begin
    if (!rst_n)                q_o = '0;
    else if (mode == ST_OPEN)  q_o = d_i;
    else                       q_o = held_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= q_o;
  end
endmodule

// File: rtl/dbuf_dac.sv
module dbuf_dac #(
  parameter int DATA_W  = 8,
  parameter int VREF_MV = 10000,
  parameter int MV_W    = $clog2(VREF_MV + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wstrobe_n,
  input  logic              xfer_n,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] dac_code,
  output logic [MV_W-1:0]   out_mv
);
  import dbuf_dac_pkg::*;

  logic              in_open;
  logic              dac_open;
  logic [DATA_W-1:0] stage_val;
  logic [DATA_W-1:0] code_val;
  int unsigned       mv_full;

  assign in_open  = !sel_n  && !wstrobe_n;
  assign dac_open = !xfer_n && !wstrobe_n;

  dbuf_stage #(.W(DATA_W)) u_stage_in (
    .clk(clk), .rst_n(rst_n), .open_i(in_open), .d_i(data_in), .q_o(stage_val)
  );

  dbuf_stage #(.W(DATA_W)) u_stage_dac (
    .clk(clk), .rst_n(rst_n), .open_i(dac_open), .d_i(stage_val), .q_o(code_val)
  );

  assign dac_code = code_val;
  assign mv_full  = ideal_mv(int'(code_val), VREF_MV, DATA_W);
  assign out_mv   = mv_full[MV_W-1:0];
endmodule

// File: rtl/dbuf_dac_chk.sv
module dbuf_dac_chk #(
  parameter int DATA_W  = 8,
  parameter int VREF_MV = 10000,
  parameter int MV_W    = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              wstrobe_n,
  input logic              xfer_n,
  input logic [DATA_W-1:0] data_in,
  input logic [DATA_W-1:0] dac_code,
  input logic [MV_W-1:0]   out_mv
);
  localparam int unsigned SCALE = 1 << DATA_W;

  always_comb begin
    if (rst_n === 1'b0) begin
      p_reset_zero_r1: assert (dac_code == '0);
    end
  end

  p_hold_strobe_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wstrobe_n && $past(wstrobe_n) && $past(rst_n)) |-> dac_code == $past(dac_code));

  p_flow_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !wstrobe_n && !xfer_n) |-> dac_code == data_in);

  p_xfer_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_n && $past(xfer_n) && $past(rst_n)) |-> dac_code == $past(dac_code));

  p_mv_scale_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(out_mv) * SCALE <= int'(dac_code) * VREF_MV) &&
    (int'(dac_code) * VREF_MV < (int'(out_mv) + 1) * SCALE));
endmodule

bind dbuf_dac dbuf_dac_chk #(.DATA_W(DATA_W), .VREF_MV(VREF_MV), .MV_W(MV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wstrobe_n(wstrobe_n), .xfer_n(xfer_n),
  .data_in(data_in), .dac_code(dac_code), .out_mv(out_mv)
);

// File: tb/dbuf_dac_bench.sv
`timescale 1ns/1ps
module dbuf_dac_bench;
  localparam int W = 8;
  localparam int VREF = 10000;
  localparam int MVW = $clog2(VREF + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic sel_n, wstrobe_n, xfer_n;
  logic [W-1:0] data_in;
  logic [W-1:0] dac_code;
  logic [MVW-1:0] out_mv;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] m_stage = '0;
  logic [W-1:0] m_out = '0;
  bit done = 0;

  always #2 clk = ~clk;

  dbuf_dac u_dbuf_dac (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wstrobe_n(wstrobe_n), .xfer_n(xfer_n),
    .data_in(data_in), .dac_code(dac_code), .out_mv(out_mv)
  );

  function automatic int exp_mv(input int code);
    return (code * VREF) / 256;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, check 1 ns later, update model at the next posedge
  task automatic step(input logic r, input logic s, input logic w, input logic x,
                      input logic [W-1:0] d, input string req);
    logic [W-1:0] st_v, out_v;
    @(negedge clk);
    rst_n = r; sel_n = s; wstrobe_n = w; xfer_n = x; data_in = d;
    #1;
    st_v  = (!s && !w) ? d : m_stage;
    out_v = (!x && !w) ? st_v : m_out;
    if (!r) begin st_v = '0; out_v = '0; end
    check(req, int'(dac_code), int'(out_v));
    check("R7", int'(out_mv), exp_mv(int'(out_v)));
    @(posedge clk);
    m_stage = st_v;
    m_out = out_v;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; sel_n = 1; wstrobe_n = 1; xfer_n = 1; data_in = 8'h5A;
    step(0, 0, 0, 0, 8'hA5, "R1");   // reset overrides flow-through
    step(0, 1, 1, 1, 8'h33, "R1");
    step(1, 1, 1, 1, 8'h77, "R1");   // cleared registers give 0
    // two-step load
    step(1, 0, 0, 1, 8'h3C, "R2");
    step(1, 0, 0, 1, 8'h3D, "R2");
    step(1, 1, 1, 1, 8'hFF, "R4");   // close by strobe, bus busy
    step(1, 1, 0, 0, 8'h00, "R3");   // transfer 3D
    check("R3", int'(dac_code), 8'h3D);
    step(1, 1, 1, 1, 8'h11, "R4");
    // R8: stage changes, output closed
    step(1, 0, 0, 1, 8'h99, "R8");
    check("R8", int'(dac_code), 8'h3D);
    step(1, 1, 1, 0, 8'h12, "R4");   // xfer low but strobe high
    check("R4", int'(dac_code), 8'h3D);
    // R6: close staging via select while strobe stays low
    step(1, 0, 0, 1, 8'hC1, "R6");
    step(1, 1, 0, 1, 8'h02, "R6");
    step(1, 1, 0, 0, 8'h03, "R6");
    check("R6", int'(dac_code), 8'hC1);
    // R5 flow-through and full scale
    step(1, 0, 0, 0, 8'hFF, "R5");
    check("R5", int'(dac_code), 8'hFF);
    check("R7", int'(out_mv), 9960);
    step(1, 0, 0, 0, 8'h80, "R5");
    check("R7", int'(out_mv), 5000);
    step(1, 0, 0, 0, 8'h00, "R5");
    step(1, 0, 0, 0, 8'h00, "R7");
    check("R7", int'(out_mv), 0);
    // close output by xfer while strobe low (R6)
    step(1, 0, 0, 0, 8'h44, "R6");
    step(1, 0, 0, 1, 8'h45, "R6");
    check("R6", int'(dac_code), 8'h44);
    for (int i = 0; i < 400; i++) begin
      logic [3:0] c;
      c = 4'($urandom);
      step(($urandom % 32) != 0, c[0], c[1] & c[3], c[2], 8'($urandom), "R2/R3/R4");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule